// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the byte-wide configuration register file of a multi-function I/O controller. A host reaches it through two byte ports on a small I/O bus: an index port that picks a register and a data port that reads or writes the picked register. Registers are guarded. A host must first write a two-byte key to the index port. Writing an exit byte to the index port locks them again. While locked, data port writes change nothing and both ports read as zero.

Global registers below index 0x30 hold a logical device number, a soft reset trigger, two power-down enable bytes and a pin polarity byte. Index 0x30 and above is a per-device bank. The logical device number chooses which bank the data port sees. Device 0 is floppy, 3 is parallel, 4 and 5 are serial, 6 is the RTC, 7 is keyboard/mouse and 8 is common I/O. Each bank holds an activate bit, a 16-bit base address, an IRQ number, a DMA channel and five mode bytes. Device 7 also holds a second IRQ for the mouse. All bank contents are driven out continuously as decoded settings for the peripherals.

The asynchronous reset is released through a two-flop synchronizer. The block therefore leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `sio_cfg_port`

## Requirements
- R1: The unlock sequence is two consecutive index port writes, 0x51 followed by 0x23. `cfg_open` goes high after the clock edge that takes the 0x23. Unlocking sets the latched index to 0x00.
- R2: In the sequence, the byte after 0x51 must be 0x23. Any other index byte returns the block to waiting for 0x51, except 0x51 itself, which counts as a fresh first key. A data port write between the two keys also cancels the sequence.
- R3: While unlocked, writing 0xBB to the index port locks the block. While locked, data port writes have no effect, and both ports read 0x00.
- R4: While unlocked, any other index port write latches the byte as the register index. Reading the index port returns the latched index. Data port reads and writes act on the register the index selects. `bus_rdata` is combinational from `bus_sel_data` and the stored state.
- R5: Global register 0x07 holds the logical device number and reads back the written byte. Values 0 to 8 select a bank. Any larger value selects none: bank reads return 0x00 and bank writes are ignored.
- R6: In the selected bank:
  - Index 0x30 bit 0 is the activate bit, which drives `dev_act[k]`. It reads back with bits 7:1 zero.
  - Indexes 0x60 and 0x61 are the base address high and low bytes, which drive `dev_base[k*16 +: 16]`.
  - Index 0x70 is the IRQ, which drives `dev_irq[k*8 +: 8]`.
  - Index 0x74 is the DMA channel, which drives `dev_dma[k*8 +: 8]`.
- R7: Index 0x72 is a read/write register only in device 7, where it drives `mouse_irq`. In every other device it reads 0x00 and writes are ignored.
- R8: Indexes 0xF0 to 0xF4 are mode bytes 0 to 4 of the selected device. Mode byte j of device k drives `dev_mode[(k*5+j)*8 +: 8]`.
- R9: Soft reset:
  - A data write to global 0x02 with bit 0 set clears every register of every bank to 0x00. The cleared values appear on the outputs after that clock edge.
  - The device number and the other global registers are kept.
  - Global 0x02 reads as 0x00.
- R10: Global registers 0x22, 0x23 and 0x24 read back the written byte and drive `pd_direct`, `pd_auto` and `pin_pol`.
- R11: Every other index reads 0x00, and writes to it change no register and no output.
- R12: After reset, the block is locked, the index and device number are 0x00, and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_data | input | 1 | Port select: 0 selects the index port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte of the selected port |
| cfg_open | output | 1 | High while registers are unlocked |
| dev_act | output | NDEV | Activate bit per device |
| dev_base | output | NDEV*16 | Base address per device |
| dev_irq | output | NDEV*8 | IRQ per device |
| dev_dma | output | NDEV*8 | DMA channel per device |
| dev_mode | output | NDEV*NMODE*8 | Mode bytes per device |
| mouse_irq | output | 8 | Second IRQ of device 7 |
| pd_direct | output | 8 | Direct power-down enables (global 0x22) |
| pd_auto | output | 8 | Auto power-down enables (global 0x23) |
| pin_pol | output | 8 | Pin polarity options (global 0x24) |

## Verification
Directed sequences first try the key path with the correct pair, a broken pair, a repeated first key and a data write between the keys. This separates a checker that needs true adjacency from one that only looks for both bytes somewhere in the stream. Further directed cases write the same index under different device numbers, including out-of-range numbers and 0x72 outside device 7. These show whether bank selection and per-device register presence are decoded separately. Random streams then mix unlock, exit, index and data writes, soft resets and reads. A reference model in the bench checks every read and every output byte, which exposes writes that leak while locked or into the wrong bank.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {LK_IDLE, LK_KEY1, LK_OPEN} lk_state_e;

  localparam logic [7:0] KEY_FIRST   = 8'h51;
  localparam logic [7:0] KEY_SECOND  = 8'h23;
  localparam logic [7:0] KEY_EXIT    = 8'hBB;
  localparam logic [7:0] REG_SRST    = 8'h02;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_PD_DIR  = 8'h22;
  localparam logic [7:0] REG_PD_AUTO = 8'h23;
  localparam logic [7:0] REG_POL     = 8'h24;
  localparam logic [7:0] BANK_FIRST  = 8'h30;
  localparam logic [7:0] REG_ACT     = 8'h30;
  localparam logic [7:0] REG_BASE_HI = 8'h60;
  localparam logic [7:0] REG_BASE_LO = 8'h61;
  localparam logic [7:0] REG_IRQ     = 8'h70;
  localparam logic [7:0] REG_IRQ2    = 8'h72;
  localparam logic [7:0] REG_DMA     = 8'h74;
  localparam logic [7:0] REG_MODE0   = 8'hF0;
endpackage

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic [7:0] idx_o
);
  lk_state_e  st_q, st_d;
  logic [7:0] idx_q, idx_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      LK_IDLE: begin
        if (idx_wr && wdata == KEY_FIRST) st_d = LK_KEY1;
      end
      LK_KEY1: begin
        if (idx_wr) begin
          if (wdata == KEY_SECOND) begin
            st_d  = LK_OPEN;
            idx_d = '0;
          end else if (wdata != KEY_FIRST) begin
            st_d = LK_IDLE;
          end
        end else if (data_wr) begin
          st_d = LK_IDLE;
        end
      end
      LK_OPEN: begin
        if (idx_wr) begin
          if (wdata == KEY_EXIT) st_d = LK_IDLE;
          else                   idx_d = wdata;
        end
      end
      default: st_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LK_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign open_o = (st_q == LK_OPEN);
  assign idx_o  = idx_q;
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
  import sio_cfg_pkg::*;
#(
  parameter int NMODE    = 5,
  parameter bit HAS_IRQ2 = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srst,
  input  logic               wr_en,
  input  logic [7:0]         idx,
  input  logic [7:0]         wdata,
  output logic               act_o,
  output logic [15:0]        base_o,
  output logic [7:0]         irq_o,
  output logic [7:0]         irq2_o,
  output logic [7:0]         dma_o,
  output logic [NMODE*8-1:0] mode_o,
  output logic [7:0]         rdata_o
);
  logic        act_q, act_d;
  logic [15:0] base_q, base_d;
  logic [7:0]  irq_q, irq_d, dma_q, dma_d;
  logic [7:0]  mode_q [NMODE];
  logic [7:0]  mode_d [NMODE];

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    irq_d  = irq_q;
    dma_d  = dma_q;
    mode_d = mode_q;
    if (srst) begin
      act_d  = 1'b0;
      base_d = '0;
      irq_d  = '0;
      dma_d  = '0;
      for (int j = 0; j < NMODE; j++) mode_d[j] = '0;
    end else if (wr_en) begin
      case (idx)
        REG_ACT:     act_d = wdata[0];
        REG_BASE_HI: base_d[15:8] = wdata;
        REG_BASE_LO: base_d[7:0]  = wdata;
        REG_IRQ:     irq_d = wdata;
        REG_DMA:     dma_d = wdata;
        default: ;
      endcase
      for (int j = 0; j < NMODE; j++)
        if (idx == REG_MODE0 + 8'(j)) mode_d[j] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      irq_q  <= '0;
      dma_q  <= '0;
      for (int j = 0; j < NMODE; j++) mode_q[j] <= '0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      irq_q  <= irq_d;
      dma_q  <= dma_d;
      mode_q <= mode_d;
    end
  end

  generate
    if (HAS_IRQ2) begin : g_irq2
      logic [7:0] irq2_q, irq2_d;
      always_comb begin
        irq2_d = irq2_q;
        if (srst)                          irq2_d = '0;
        else if (wr_en && idx == REG_IRQ2) irq2_d = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq2_q <= '0;
        else        irq2_q <= irq2_d;
      end
      assign irq2_o = irq2_q;
    end else begin : g_no_irq2
      assign irq2_o = '0;
    end

    for (genvar j = 0; j < NMODE; j++) begin : g_mode_out
      assign mode_o[j*8 +: 8] = mode_q[j];
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    case (idx)
      REG_ACT:     rdata_o = {7'b0, act_q};
      REG_BASE_HI: rdata_o = base_q[15:8];
      REG_BASE_LO: rdata_o = base_q[7:0];
      REG_IRQ:     rdata_o = irq_q;
      REG_IRQ2:    rdata_o = irq2_o;
      REG_DMA:     rdata_o = dma_q;
      default: ;
    endcase
    for (int j = 0; j < NMODE; j++)
      if (idx == REG_MODE0 + 8'(j)) rdata_o = mode_q[j];
  end

  assign act_o  = act_q;
  assign base_o = base_q;
  assign irq_o  = irq_q;
  assign dma_o  = dma_q;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int NDEV      = 9,
  parameter int NMODE     = 5,
  parameter int MOUSE_DEV = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel_data,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  output logic                    cfg_open,
  output logic [NDEV-1:0]         dev_act,
  output logic [NDEV*16-1:0]      dev_base,
  output logic [NDEV*8-1:0]       dev_irq,
  output logic [NDEV*8-1:0]       dev_dma,
  output logic [NDEV*NMODE*8-1:0] dev_mode,
  output logic [7:0]              mouse_irq,
  output logic [7:0]              pd_direct,
  output logic [7:0]              pd_auto,
  output logic [7:0]              pin_pol
);
  localparam int MODE_BITS = NMODE * 8;

  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_meta} <= 2'b00;
    else        {rst_s, rst_meta} <= {rst_meta, 1'b1};
  end

  logic       idx_wr, data_wr, cfg_wr, bank_area, srst;
  logic [7:0] idx_q;

  assign idx_wr  = bus_wr && !bus_sel_data;
  assign data_wr = bus_wr && bus_sel_data;

  sio_cfg_unlock u_unlock (
    .clk     (clk),
    .rst_n   (rst_s),
    .idx_wr  (idx_wr),
    .data_wr (data_wr),
    .wdata   (bus_wdata),
    .open_o  (cfg_open),
    .idx_o   (idx_q)
  );

  assign cfg_wr    = data_wr && cfg_open;
  assign bank_area = (idx_q >= BANK_FIRST);
  assign srst      = cfg_wr && (idx_q == REG_SRST) && bus_wdata[0];

  logic [7:0] ldn_q, ldn_d, pdd_q, pdd_d, pda_q, pda_d, pol_q, pol_d;

  always_comb begin
    ldn_d = ldn_q;
    pdd_d = pdd_q;
    pda_d = pda_q;
    pol_d = pol_q;
    if (cfg_wr) begin
      case (idx_q)
        REG_LDN:     ldn_d = bus_wdata;
        REG_PD_DIR:  pdd_d = bus_wdata;
        REG_PD_AUTO: pda_d = bus_wdata;
        REG_POL:     pol_d = bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ldn_q <= '0;
      pdd_q <= '0;
      pda_q <= '0;
      pol_q <= '0;
    end else begin
      ldn_q <= ldn_d;
      pdd_q <= pdd_d;
      pda_q <= pda_d;
      pol_q <= pol_d;
    end
  end

  logic [7:0] bank_rd   [NDEV];
  logic [7:0] bank_irq2 [NDEV];

  generate
    for (genvar k = 0; k < NDEV; k++) begin : g_bank
      logic sel;
      assign sel = (ldn_q == 8'(k));
      sio_dev_bank #(
        .NMODE    (NMODE),
        .HAS_IRQ2 (k == MOUSE_DEV)
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_s),
        .srst    (srst),
        .wr_en   (cfg_wr && bank_area && sel),
        .idx     (idx_q),
        .wdata   (bus_wdata),
        .act_o   (dev_act[k]),
        .base_o  (dev_base[k*16 +: 16]),
        .irq_o   (dev_irq[k*8 +: 8]),
        .irq2_o  (bank_irq2[k]),
        .dma_o   (dev_dma[k*8 +: 8]),
        .mode_o  (dev_mode[k*MODE_BITS +: MODE_BITS]),
        .rdata_o (bank_rd[k])
      );
    end
  endgenerate

  always_comb begin
    mouse_irq = '0;
    for (int k = 0; k < NDEV; k++) mouse_irq = mouse_irq | bank_irq2[k];
  end

  logic [7:0] glb_rd, bank_mux;
  always_comb begin
    bank_mux = '0;
    for (int k = 0; k < NDEV; k++)
      if (ldn_q == 8'(k)) bank_mux = bank_rd[k];
    case (idx_q)
      REG_LDN:     glb_rd = ldn_q;
      REG_PD_DIR:  glb_rd = pdd_q;
      REG_PD_AUTO: glb_rd = pda_q;
      REG_POL:     glb_rd = pol_q;
      default:     glb_rd = '0;
    endcase
    if (!cfg_open)         bus_rdata = '0;
    else if (!bus_sel_data) bus_rdata = idx_q;
    else if (bank_area)    bus_rdata = bank_mux;
    else                   bus_rdata = glb_rd;
  end

  assign pd_direct = pdd_q;
  assign pd_auto   = pda_q;
  assign pin_pol   = pol_q;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int NDEV = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel_data,
  input logic            bus_wr,
  input logic [7:0]      bus_wdata,
  input logic [7:0]      bus_rdata,
  input logic            cfg_open,
  input logic [NDEV-1:0] dev_act,
  input logic [7:0]      pd_direct
);
  // R1: opening only follows an index write of the second key
  a_r1_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(bus_wr && !bus_sel_data && bus_wdata == 8'h23));

  // R3: exit byte closes the port
  a_r3_exit_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && bus_wr && !bus_sel_data && bus_wdata == 8'hBB) |=> !cfg_open);

  // R3: closing only follows the exit byte
  a_r3_close_needs_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_open) |-> $past(bus_wr && !bus_sel_data && bus_wdata == 8'hBB));

  // R3: locked port reads zero
  a_r3_locked_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> bus_rdata == 8'h00);

  // R3: nothing changes while locked
  a_r3_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(dev_act) && $stable(pd_direct)));

  // R4: index port reads back the byte just latched
  a_r4_index_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && bus_wr && !bus_sel_data && bus_wdata != 8'hBB)
      |=> (!bus_sel_data -> bus_rdata == $past(bus_wdata)));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.NDEV(NDEV)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel_data (bus_sel_data),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .cfg_open     (cfg_open),
  .dev_act      (dev_act),
  .pd_direct    (pd_direct)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  localparam int NDEV = 9;
  localparam int NMODE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel_data = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic cfg_open;
  logic [NDEV-1:0] dev_act;
  logic [NDEV*16-1:0] dev_base;
  logic [NDEV*8-1:0] dev_irq, dev_dma;
  logic [NDEV*NMODE*8-1:0] dev_mode;
  logic [7:0] mouse_irq, pd_direct, pd_auto, pin_pol;

  always #10 clk = ~clk;

  sio_cfg_port u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic m_open, m_key1;
  logic [7:0] m_idx, m_ldn, m_pdd, m_pda, m_pol;
  logic [7:0] m_bank [0:NDEV-1][0:255];

  function automatic bit impl(int dev, logic [7:0] idx);
    if (idx == 8'h30 || idx == 8'h60 || idx == 8'h61 || idx == 8'h70 || idx == 8'h74) return 1;
    if (idx >= 8'hF0 && idx <= 8'hF4) return 1;
    if (dev == 7 && idx == 8'h72) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] exp_data();
    if (!m_open) return 8'h00;
    if (m_idx < 8'h30) begin
      case (m_idx)
        8'h07: return m_ldn;
        8'h22: return m_pdd;
        8'h23: return m_pda;
        8'h24: return m_pol;
        default: return 8'h00;
      endcase
    end
    if (m_ldn < NDEV && impl(int'(m_ldn), m_idx)) return m_bank[m_ldn][m_idx];
    return 8'h00;
  endfunction

  task automatic model_reset();
    m_open = 0; m_key1 = 0; m_idx = 0; m_ldn = 0; m_pdd = 0; m_pda = 0; m_pol = 0;
    for (int d = 0; d < NDEV; d++) for (int i = 0; i < 256; i++) m_bank[d][i] = 8'h00;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] b);
    @(negedge clk);
    bus_sel_data = sel; bus_wr = 1'b1; bus_wdata = b;
    @(negedge clk);
    bus_wr = 1'b0;
    if (!sel) begin
      if (m_open) begin
        if (b == 8'hBB) m_open = 0; else m_idx = b;
      end else if (m_key1) begin
        if (b == 8'h23) begin m_open = 1; m_key1 = 0; m_idx = 0; end
        else if (b != 8'h51) m_key1 = 0;
      end else if (b == 8'h51) m_key1 = 1;
    end else if (!m_open) begin
      m_key1 = 0;
    end else if (m_idx < 8'h30) begin
      case (m_idx)
        8'h02: if (b[0]) for (int d = 0; d < NDEV; d++) for (int i = 0; i < 256; i++) m_bank[d][i] = 0;
        8'h07: m_ldn = b;
        8'h22: m_pdd = b;
        8'h23: m_pda = b;
        8'h24: m_pol = b;
        default: ;
      endcase
    end else if (m_ldn < NDEV && impl(int'(m_ldn), m_idx)) begin
      m_bank[m_ldn][m_idx] = (m_idx == 8'h30) ? {7'b0, b[0]} : b;
    end
  endtask

  task automatic check_all(string req);
    check(req, "cfg_open", 32'(cfg_open), 32'(m_open));
    bus_sel_data = 1'b0; #1;
    check(req, "index port", 32'(bus_rdata), m_open ? 32'(m_idx) : 32'h0);
    bus_sel_data = 1'b1; #1;
    check(req, "data port", 32'(bus_rdata), 32'(exp_data()));
    for (int d = 0; d < NDEV; d++) begin
      check(req, $sformatf("act%0d", d), 32'(dev_act[d]), 32'(m_bank[d][8'h30][0]));
      check(req, $sformatf("base%0d", d), 32'(dev_base[d*16 +: 16]), {16'h0, m_bank[d][8'h60], m_bank[d][8'h61]});
      check(req, $sformatf("irq%0d", d), 32'(dev_irq[d*8 +: 8]), 32'(m_bank[d][8'h70]));
      check(req, $sformatf("dma%0d", d), 32'(dev_dma[d*8 +: 8]), 32'(m_bank[d][8'h74]));
      for (int j = 0; j < NMODE; j++)
        check(req, $sformatf("mode%0d_%0d", d, j), 32'(dev_mode[(d*NMODE+j)*8 +: 8]), 32'(m_bank[d][8'hF0+j]));
    end
    check(req, "mouse_irq", 32'(mouse_irq), 32'(m_bank[7][8'h72]));
    check(req, "pd_direct", 32'(pd_direct), 32'(m_pdd));
    check(req, "pd_auto", 32'(pd_auto), 32'(m_pda));
    check(req, "pin_pol", 32'(pin_pol), 32'(m_pol));
  endtask

  task automatic unlock();
    wr(0, 8'h51); wr(0, 8'h23);
  endtask

  task automatic put(logic [7:0] idx, logic [7:0] val);
    wr(0, idx); wr(1, val);
  endtask

  function automatic logic [7:0] pick_idx(int r);
    case (r % 20)
      0: return 8'h02;  1: return 8'h07;  2: return 8'h22;  3: return 8'h23;
      4: return 8'h24;  5: return 8'h30;  6: return 8'h60;  7: return 8'h61;
      8: return 8'h70;  9: return 8'h72; 10: return 8'h74; 11: return 8'hF0;
      12: return 8'hF1; 13: return 8'hF2; 14: return 8'hF3; 15: return 8'hF4;
      16: return 8'hF5; 17: return 8'h31; 18: return 8'h00;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R12");

    // R3: locked writes ignored
    wr(1, 8'hFF); check_all("R3");
    // R2: broken sequence
    wr(0, 8'h51); wr(0, 8'h00); wr(0, 8'h23); check_all("R2");
    // R2: data write between keys
    wr(0, 8'h51); wr(1, 8'h23); wr(0, 8'h23); check_all("R2");
    // R2: repeated first key
    wr(0, 8'h51); wr(0, 8'h51); wr(0, 8'h23); check_all("R2");
    // R1: proper unlock from idle
    wr(0, 8'hBB); unlock(); check_all("R1");
    // R4 and R10: globals
    put(8'h22, 8'hA5); put(8'h23, 8'h3C); put(8'h24, 8'h81); check_all("R10");
    // R6 and R8 on device 3
    put(8'h07, 8'h03);
    put(8'h30, 8'hFF); put(8'h60, 8'h03); put(8'h61, 8'h78);
    put(8'h70, 8'h07); put(8'h74, 8'h03); put(8'hF0, 8'hBC); put(8'hF4, 8'h05);
    check_all("R6");
    wr(0, 8'hF4); check_all("R8");
    // R7: 0x72 outside device 7 ignored, inside stored
    put(8'h72, 8'h0C); check_all("R7");
    put(8'h07, 8'h07); put(8'h72, 8'h0C); check_all("R7");
    // R5: out-of-range device number
    put(8'h07, 8'h09); put(8'h70, 8'h55); wr(0, 8'h70); check_all("R5");
    put(8'h07, 8'hFF); put(8'h30, 8'h01); check_all("R5");
    // R11: unimplemented indexes
    put(8'h07, 8'h00); put(8'h31, 8'h77); put(8'hF5, 8'h66); put(8'h10, 8'h44); check_all("R11");
    // R9: soft reset
    put(8'h30, 8'h01); put(8'h02, 8'h00); check_all("R9");
    put(8'h02, 8'h01); check_all("R9");
    wr(0, 8'h07); check_all("R9");
    // R3: exit then locked reads and writes
    wr(0, 8'hBB); wr(1, 8'h12); check_all("R3");

    for (int n = 0; n < 1500; n++) begin
      int r;
      r = int'($urandom % 32);
      if (r == 0)       wr(0, 8'($urandom));
      else if (r <= 2)  wr(0, 8'h51);
      else if (r <= 4)  wr(0, 8'h23);
      else if (r == 5)  wr(0, 8'hBB);
      else if (r <= 12) wr(0, pick_idx(int'($urandom % 64)));
      else if (r <= 22) begin
        if (m_idx == 8'h07) wr(1, 8'($urandom % 10));
        else if (m_idx == 8'h02) wr(1, 8'($urandom % 8) & 8'hFE | 8'(($urandom % 6) == 0));
        else wr(1, 8'($urandom));
      end else if (r <= 26) begin
        if (!m_open) unlock();
      end
      if (r >= 27 || (n % 50) == 49) check_all("R4");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule